// File: doc/BRIEF.md
# Programmable-Timing I2C Master Byte Engine

This block is a single-master I2C engine that moves exactly one byte for each start request. All bus timing comes from cycle counts supplied on input ports: the SCL low time, the SCL high time, the setup before START, the setup before STOP, and the delay from each SCL falling edge to the SDA update. A transfer consists of START, eight data slots, one acknowledge slot, and STOP. In a write, the engine drives the latched transmit byte and samples the acknowledge. In a read, it releases SDA, samples the data, and answers the ninth slot with a NACK.

The engine reports busy, byte-done, the sampled acknowledge, and the received byte. A non-zero whole-transfer limit aborts a transfer that runs too long. If another driver pulls SDA low while the engine releases it during a written data bit, the engine abandons the bus. Both abort kinds release the lines, set a sticky flag and produce a one-cycle event pulse. Transmit and receive bit order are selected independently. Each line can be driven open-drain or push-pull.

Timing inputs are expected to stay constant during a transfer. The SDA delay must be smaller than the effective SCL low count. The returned SDA is assumed to be synchronous to the clock.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset both lines are released (level 1), and busy, byte_done, timed_out, arb_lost, both event pulses, rx_byte and ack_val are all 0.
- R2: When go is sampled high while idle, busy rises the next cycle. Both lines then stay high for t_start_su cycles. After that SDA is low with SCL high for t_high cycles, and then SCL falls. A count of 0 acts as 1 for every timing input.
- R3: Each of the nine slots holds SCL low for t_low cycles and then high for t_high cycles. SDA takes the slot's value t_sda_dly cycles after SCL falls (0 means in the first low cycle) and does not change while SCL is high.
- R4: In a write, wire data slot i carries tx_byte[7-i] when tx_lsb_first=0 and tx_byte[i] when it is 1. The byte and the order select are latched when go is accepted. The ninth slot is released. ack_val takes SDA as sampled at high-phase cycle floor(t_high/2) of that slot, and a sampled 1 (NACK) still completes STOP.
- R5: In a read, all nine slots are released. SDA is sampled at high-phase cycle floor(t_high/2) and stored into rx_byte bit 7-i (rx_lsb_first=0) or bit i (rx_lsb_first=1), visible from the next cycle.
- R6: After the ninth slot, SCL is low for t_low cycles with SDA going low after t_sda_dly cycles. SCL is then high for t_stop_su cycles with SDA low. Then SDA is released in the same cycle in which busy drops.
- R7: byte_done rises in the cycle SCL falls after the eighth data slot. The next accepted go clears byte_done, timed_out and arb_lost. A go that arrives while busy is ignored, as are changes to tx_byte after acceptance.
- R8: With t_limit non-zero, a transfer still busy after t_limit busy cycles is aborted: both lines are released, busy drops, timed_out is set and timeout_evt pulses for one cycle. t_limit=0 disables the limit.
- R9: In a write data slot whose driven value is 1, a 0 sampled at the sample point aborts the transfer: both lines are released, busy drops, arb_lost is set and arb_evt pulses for one cycle.
- R10: In open-drain mode (pp=0), a line driven low has oe=1 and o=0, and a released line has oe=0 and o=0. In push-pull mode (pp=1), oe=1 and o equals the level. The mode is selected separately for each line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go | input | 1 | Start request, accepted only while idle |
| rd_sel | input | 1 | 1 = read, 0 = write |
| tx_byte | input | 8 | Byte to transmit |
| tx_lsb_first | input | 1 | Transmit order select |
| rx_lsb_first | input | 1 | Receive order select |
| scl_pp | input | 1 | SCL push-pull select |
| sda_pp | input | 1 | SDA push-pull select |
| t_low | input | 19 | SCL low cycles |
| t_high | input | 20 | SCL high cycles |
| t_start_su | input | 20 | Cycles before START |
| t_stop_su | input | 20 | Cycles before STOP |
| t_sda_dly | input | 20 | SDA update delay after SCL falls |
| t_limit | input | 20 | Transfer cycle limit, 0 = off |
| sda_in | input | 1 | SDA level seen on the bus |
| scl_oe | output | 1 | SCL output enable |
| scl_o | output | 1 | SCL output value |
| sda_oe | output | 1 | SDA output enable |
| sda_o | output | 1 | SDA output value |
| rx_byte | output | 8 | Received byte |
| ack_val | output | 1 | Sampled acknowledge value |
| busy | output | 1 | Transfer in progress |
| byte_done | output | 1 | Eight data bits finished |
| timed_out | output | 1 | Sticky timeout flag |
| arb_lost | output | 1 | Sticky arbitration-lost flag |
| timeout_evt | output | 1 | One-cycle timeout event |
| arb_evt | output | 1 | One-cycle arbitration-lost event |

## Verification
Every line level is due in the cycle after the clock edge on which the relevant phase count expires. A received bit or acknowledge is due in the cycle after high-phase cycle floor(t_high/2). byte_done and both event pulses appear one cycle after the edge that causes them. The reference model advances exactly one clock per step and follows these rules. It accumulates counts with plain integers, and each step is compared against every output half a period after the edge, so a result that arrives one cycle early or late shows up as a mismatch.

// File: rtl/i2cb_pkg.sv
// Shared types and helpers for the I2C master byte engine.
// Assumes byte-wide transfers with a ninth acknowledge slot.
package i2cb_pkg;
    localparam int BYTE_W  = 8;
    localparam int SLOT_N  = BYTE_W + 1;
    localparam int IDX_W   = $clog2(SLOT_N + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START_SU,
        ST_START_HOLD,
        ST_LOW,
        ST_HIGH,
        ST_STOP_LOW,
        ST_STOP_SU
    } i2cb_state_e;

    // Maps the wire slot number to a byte bit position for the chosen order.
    function automatic logic [2:0] bit_pos(input logic [2:0] slot, input logic lsb_first);
        return lsb_first ? slot : 3'(7 - int'(slot));
    endfunction
endpackage

// File: rtl/i2cb_phase_cnt.sv
// Phase counter: counts cycles inside the current bus phase and flags the
// phase's last cycle. A target of 0 is treated as 1.
// Assumes restart is asserted on the edge that begins a new phase.
module i2cb_phase_cnt #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic [W-1:0] target,
    output logic [W-1:0] count,
    output logic         last
);
    logic [W-1:0] tgt_m1;

    // Last index of the phase, zero target folded to one cycle.
    always_comb tgt_m1 = (target == '0) ? '0 : target - 1'b1;

    assign last = (count >= tgt_m1);

    // Cycle counter, cleared at each phase boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)       count <= '0;
        else if (restart) count <= '0;
        else              count <= count + 1'b1;
    end
endmodule

// File: rtl/i2cb_xfer_timer.sv
// Whole-transfer timer: counts busy cycles and flags the cycle in which the
// limit is reached. A limit of 0 disables it. Clears whenever run is low.
module i2cb_xfer_timer #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         expire
);
    logic [W-1:0] elapsed;

    assign expire = run && (limit != '0) && (elapsed == limit - 1'b1);

    // Busy-cycle count, saturating at all ones.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)    elapsed <= '0;
        else if (elapsed != '1) elapsed <= elapsed + 1'b1;
    end
endmodule

// File: rtl/i2cb_pad.sv
// Line driver: converts a wanted line level into output-enable and value
// for either open-drain (release when high) or push-pull driving.
module i2cb_pad (
    input  logic level,
    input  logic pp,
    output logic oe,
    output logic o
);
    assign oe = pp | ~level;
    assign o  = pp & level;
endmodule

// File: rtl/i2c_byte_master.sv
// One-byte I2C master with programmable phase timing, transfer limit and
// arbitration detection. Assumes sda_in is synchronous to clk, timing inputs
// are static during a transfer and t_sda_dly is below the effective t_low.
module i2c_byte_master #(
    parameter int LOW_W = 19,
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             rd_sel,
    input  logic [7:0]       tx_byte,
    input  logic             tx_lsb_first,
    input  logic             rx_lsb_first,
    input  logic             scl_pp,
    input  logic             sda_pp,
    input  logic [LOW_W-1:0] t_low,
    input  logic [CNT_W-1:0] t_high,
    input  logic [CNT_W-1:0] t_start_su,
    input  logic [CNT_W-1:0] t_stop_su,
    input  logic [CNT_W-1:0] t_sda_dly,
    input  logic [CNT_W-1:0] t_limit,
    input  logic             sda_in,
    output logic             scl_oe,
    output logic             scl_o,
    output logic             sda_oe,
    output logic             sda_o,
    output logic [7:0]       rx_byte,
    output logic             ack_val,
    output logic             busy,
    output logic             byte_done,
    output logic             timed_out,
    output logic             arb_lost,
    output logic             timeout_evt,
    output logic             arb_evt
);
    import i2cb_pkg::*;

    localparam logic [IDX_W-1:0] LAST_DATA = IDX_W'(BYTE_W - 1);
    localparam logic [IDX_W-1:0] ACK_SLOT  = IDX_W'(BYTE_W);

    i2cb_state_e      state;
    logic [IDX_W-1:0] slot;
    logic [7:0]       tx_q;
    logic             rd_q, txl_q, rxl_q;
    logic             scl_lvl, sda_lvl;
    logic [CNT_W-1:0] tgt, cnt, th_eff, half;
    logic             last, expire, samp, dly_hit, xfer_end, arb_hit, tmo_hit, abort;

    // Value SDA should carry in a given slot.
    function automatic logic slot_bit(input logic [IDX_W-1:0] idx);
        if (idx < ACK_SLOT && !rd_q) return tx_q[bit_pos(idx[2:0], txl_q)];
        return 1'b1;
    endfunction

    assign busy = (state != ST_IDLE);

    // Phase length selected by the current state.
    always_comb begin
        case (state)
            ST_START_SU:             tgt = t_start_su;
            ST_START_HOLD, ST_HIGH:  tgt = t_high;
            ST_LOW, ST_STOP_LOW:     tgt = CNT_W'(t_low);
            ST_STOP_SU:              tgt = t_stop_su;
            default:                 tgt = '0;
        endcase
    end

    // Sample point, SDA update point and abort conditions.
    always_comb begin
        th_eff   = (t_high == '0) ? CNT_W'(1) : t_high;
        half     = th_eff >> 1;
        samp     = (state == ST_HIGH) && (cnt == half);
        dly_hit  = (state == ST_LOW || state == ST_STOP_LOW) && (t_sda_dly != '0)
                   && (cnt == t_sda_dly - 1'b1);
        xfer_end = (state == ST_STOP_SU) && last;
        arb_hit  = samp && !rd_q && (slot < ACK_SLOT) && sda_lvl && !sda_in;
        tmo_hit  = expire && !xfer_end && !arb_hit;
        abort    = arb_hit || tmo_hit;
    end

    i2cb_phase_cnt #(.W(CNT_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .restart((state == ST_IDLE) || last || abort),
        .target(tgt), .count(cnt), .last(last)
    );

    i2cb_xfer_timer #(.W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(busy), .limit(t_limit), .expire(expire)
    );

    // One driver per line: index 0 is SCL, index 1 is SDA.
    logic [1:0] lvl_v, pp_v, oe_v, o_v;
    assign lvl_v = {sda_lvl, scl_lvl};
    assign pp_v  = {sda_pp, scl_pp};
    for (genvar g = 0; g < 2; g++) begin : g_pad
        i2cb_pad u_pad (.level(lvl_v[g]), .pp(pp_v[g]), .oe(oe_v[g]), .o(o_v[g]));
    end
    assign scl_oe = oe_v[0];
    assign scl_o  = o_v[0];
    assign sda_oe = oe_v[1];
    assign sda_o  = o_v[1];

    // Transfer sequencer: phases, line levels, sampling and status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;   slot <= '0;       tx_q <= '0;
            rd_q <= 1'b0;       txl_q <= 1'b0;    rxl_q <= 1'b0;
            scl_lvl <= 1'b1;    sda_lvl <= 1'b1;  rx_byte <= '0;
            ack_val <= 1'b0;    byte_done <= 1'b0;
            timed_out <= 1'b0;  arb_lost <= 1'b0;
            timeout_evt <= 1'b0; arb_evt <= 1'b0;
        end else begin
            timeout_evt <= 1'b0;
            arb_evt     <= 1'b0;
            if (abort) begin
                state   <= ST_IDLE;
                scl_lvl <= 1'b1;
                sda_lvl <= 1'b1;
                if (arb_hit) begin arb_lost  <= 1'b1; arb_evt     <= 1'b1; end
                else         begin timed_out <= 1'b1; timeout_evt <= 1'b1; end
            end else begin
                case (state)
                    ST_IDLE: if (go) begin
                        state <= ST_START_SU;  slot <= '0;
                        tx_q  <= tx_byte;      rd_q <= rd_sel;
                        txl_q <= tx_lsb_first; rxl_q <= rx_lsb_first;
                        byte_done <= 1'b0; timed_out <= 1'b0; arb_lost <= 1'b0;
                    end
                    ST_START_SU: if (last) begin
                        sda_lvl <= 1'b0;
                        state   <= ST_START_HOLD;
                    end
                    ST_START_HOLD: if (last) begin
                        scl_lvl <= 1'b0;
                        state   <= ST_LOW;
                        if (t_sda_dly == '0) sda_lvl <= slot_bit(slot);
                    end
                    ST_LOW: begin
                        if (dly_hit) sda_lvl <= slot_bit(slot);
                        if (last) begin scl_lvl <= 1'b1; state <= ST_HIGH; end
                    end
                    ST_HIGH: begin
                        if (samp) begin
                            if (slot == ACK_SLOT) ack_val <= sda_in;
                            else if (rd_q) rx_byte[bit_pos(slot[2:0], rxl_q)] <= sda_in;
                        end
                        if (last) begin
                            scl_lvl <= 1'b0;
                            if (slot == LAST_DATA) byte_done <= 1'b1;
                            if (slot == ACK_SLOT) begin
                                state <= ST_STOP_LOW;
                                if (t_sda_dly == '0) sda_lvl <= 1'b0;
                            end else begin
                                slot  <= slot + 1'b1;
                                state <= ST_LOW;
                                if (t_sda_dly == '0) sda_lvl <= slot_bit(slot + 1'b1);
                            end
                        end
                    end
                    ST_STOP_LOW: begin
                        if (dly_hit) sda_lvl <= 1'b0;
                        if (last) begin scl_lvl <= 1'b1; state <= ST_STOP_SU; end
                    end
                    ST_STOP_SU: if (last) begin
                        sda_lvl <= 1'b1;
                        state   <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R3
    data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HIGH && $past(state) == ST_HIGH) |-> $stable(sda_lvl));

    // R6
    release_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (scl_lvl && sda_lvl));

    // R7
    tx_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(tx_q));

    // R7
    byte_done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(byte_done) |-> (state == ST_LOW && slot == ACK_SLOT && !scl_lvl));

    // R8
    timeout_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_evt |-> (timed_out && !busy));

    // R9
    arb_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arb_evt |-> (arb_lost && !busy && sda_lvl));
endmodule

// File: tb/tb_i2c_byte_master.sv
module tb_i2c_byte_master;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic go = 1'b0, rd_sel = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic tx_lsb = 1'b0, rx_lsb = 1'b0, scl_pp = 1'b0, sda_pp = 1'b0;
    int ts = 3, th = 4, tl = 5, td = 2, tp = 3, tlim = 0;
    logic spull = 1'b0;
    logic scl_oe, scl_o, sda_oe, sda_o, sda_in;
    logic [7:0] rx_byte;
    logic ack_val, busy, byte_done, timed_out, arb_lost, timeout_evt, arb_evt;

    always #4 clk = ~clk;   // 125 MHz

    assign sda_in = (sda_oe ? sda_o : 1'b1) & ~spull;

    i2c_byte_master dut (
        .clk(clk), .rst_n(rst_n), .go(go), .rd_sel(rd_sel), .tx_byte(tx_byte),
        .tx_lsb_first(tx_lsb), .rx_lsb_first(rx_lsb), .scl_pp(scl_pp), .sda_pp(sda_pp),
        .t_low(tl[18:0]), .t_high(th[19:0]), .t_start_su(ts[19:0]), .t_stop_su(tp[19:0]),
        .t_sda_dly(td[19:0]), .t_limit(tlim[19:0]), .sda_in(sda_in),
        .scl_oe(scl_oe), .scl_o(scl_o), .sda_oe(sda_oe), .sda_o(sda_o),
        .rx_byte(rx_byte), .ack_val(ack_val), .busy(busy), .byte_done(byte_done),
        .timed_out(timed_out), .arb_lost(arb_lost), .timeout_evt(timeout_evt), .arb_evt(arb_evt)
    );

    // Reference model state
    bit m_scl = 1, m_sda = 1, m_busy = 0, m_done = 0, m_to = 0, m_arb = 0;
    bit m_tevt = 0, m_aevt = 0, m_ack = 0, m_abort = 0;
    logic [7:0] m_rx = 8'h00;
    int m_bc = 0;
    string m_req = "R1";
    bit cmp_en = 0;
    int checks = 0, errors = 0, cyc = 0;

    task automatic fail(string req, string what, int act, int exp);
        errors++;
        $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    endtask

    function automatic int eff(int v);
        return (v == 0) ? 1 : v;
    endfunction

    // Pad encoding expected for a wanted level.
    function automatic bit pad_ok(bit pp, bit lvl, logic oe, logic o);
        if (pp) return (oe == 1'b1) && (o == lvl);
        return (oe == !lvl) && (o == 1'b0);
    endfunction

    // Compare every output against the model, half a period after the edge.
    always @(negedge clk) begin
        #1;
        if (cmp_en) begin
            checks++;
            if ((scl_oe ? scl_o : 1'b1) !== m_scl) fail(m_req, "scl", int'(scl_o), int'(m_scl));
            if ((sda_oe ? sda_o : 1'b1) !== m_sda) fail(m_req, "sda", int'(sda_o), int'(m_sda));
            if (!pad_ok(scl_pp, m_scl, scl_oe, scl_o)) fail("R10", "scl pad", int'({scl_oe, scl_o}), int'(m_scl));
            if (!pad_ok(sda_pp, m_sda, sda_oe, sda_o)) fail("R10", "sda pad", int'({sda_oe, sda_o}), int'(m_sda));
            if (busy !== m_busy) fail("R7", "busy", int'(busy), int'(m_busy));
            if (byte_done !== m_done) fail("R7", "byte_done", int'(byte_done), int'(m_done));
            if (rx_byte !== m_rx) fail("R5", "rx_byte", int'(rx_byte), int'(m_rx));
            if (ack_val !== m_ack) fail("R4", "ack_val", int'(ack_val), int'(m_ack));
            if (timed_out !== m_to) fail("R8", "timed_out", int'(timed_out), int'(m_to));
            if (timeout_evt !== m_tevt) fail("R8", "timeout_evt", int'(timeout_evt), int'(m_tevt));
            if (arb_lost !== m_arb) fail("R9", "arb_lost", int'(arb_lost), int'(m_arb));
            if (arb_evt !== m_aevt) fail("R9", "arb_evt", int'(arb_evt), int'(m_aevt));
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fail("R7", "watchdog", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Advance the model by one clock, applying the transfer limit.
    task automatic step();
        @(negedge clk);
        m_tevt = 0;
        m_aevt = 0;
        if (m_busy) begin
            if (tlim != 0 && m_bc == tlim - 1) begin
                m_busy = 0; m_scl = 1; m_sda = 1; m_to = 1; m_tevt = 1;
                m_abort = 1; spull = 0; m_req = "R8";
            end else m_bc++;
        end
    endtask

    task automatic hold(int n);
        for (int k = 0; k < n; k++) if (!m_abort) step();
    endtask

    // Drives one transfer and walks the model through it.
    task automatic run_xfer(bit rd, logic [7:0] tx, logic [7:0] slave, bit ack_pull,
                            int arb_slot, bit poke);
        bit v, pull, smp;
        m_abort = 0;
        rd_sel = rd; tx_byte = tx; go = 1'b1;
        step();
        go = 1'b0;
        tx_byte = ~tx;                       // R7: ignored after acceptance
        m_busy = 1; m_bc = 0; m_done = 0; m_to = 0; m_arb = 0;
        m_scl = 1; m_sda = 1; m_req = "R2";
        hold(eff(ts));
        if (m_abort) return;
        m_sda = 0;
        if (poke) begin go = 1'b1; step(); go = 1'b0; hold(eff(th) - 1); end
        else hold(eff(th));
        if (m_abort) return;
        for (int i = 0; i < 9; i++) begin
            m_req = (i == 8) ? (rd ? "R5" : "R4") : (rd ? "R5" : "R4");
            v    = (i < 8 && !rd) ? tx[tx_lsb ? i : 7 - i] : 1'b1;
            pull = (i < 8) ? (rd ? ~slave[7 - i] : (i == arb_slot)) : ack_pull;
            m_scl = 0;
            if (td == 0) begin
                m_sda = v; spull = pull; hold(eff(tl));
            end else begin
                hold(td);
                if (m_abort) return;
                m_sda = v; spull = pull; hold(eff(tl) - td);
            end
            if (m_abort) return;
            m_scl = 1; m_req = "R3";
            hold(eff(th) / 2 + 1);
            if (m_abort) return;
            smp = m_sda & ~spull;
            if (i < 8 && !rd && m_sda && !smp) begin   // R9 arbitration loss
                m_busy = 0; m_scl = 1; m_sda = 1; m_arb = 1; m_aevt = 1;
                m_abort = 1; spull = 0; m_req = "R9";
                return;
            end
            if (i == 8) m_ack = smp;
            else if (rd) m_rx[rx_lsb ? i : 7 - i] = smp;
            hold(eff(th) - eff(th) / 2 - 1);
            if (m_abort) return;
            if (i == 7) m_done = 1;
        end
        m_req = "R6";
        m_scl = 0;
        if (td == 0) begin
            m_sda = 0; spull = 0; hold(eff(tl));
        end else begin
            hold(td);
            if (m_abort) return;
            m_sda = 0; spull = 0; hold(eff(tl) - td);
        end
        if (m_abort) return;
        m_scl = 1;
        hold(eff(tp));
        if (m_abort) return;
        m_sda = 1; m_busy = 0; m_req = "R7";
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1;                           // R1: idle state compared from here
        hold(5);

        // R4: write MSB first, slave acknowledges, open-drain lines
        ts = 3; th = 4; tl = 5; td = 2; tp = 3; tlim = 0;
        run_xfer(0, 8'hA5, 8'h00, 1, -1, 0);
        hold(6);

        // R4, R7: write LSB first, NACK, push-pull, go poked while busy
        tx_lsb = 1; scl_pp = 1; sda_pp = 1; th = 5; tl = 4; td = 0;
        run_xfer(0, 8'h3C, 8'h00, 0, -1, 1);
        hold(6);

        // R5: read MSB first
        tx_lsb = 0; scl_pp = 0; sda_pp = 0; th = 3; tl = 6; td = 1;
        run_xfer(1, 8'h00, 8'hC6, 0, -1, 0);
        hold(6);

        // R5, R10: read LSB first, SCL push-pull, SDA open-drain
        rx_lsb = 1; scl_pp = 1; th = 2; tl = 3; td = 2;
        run_xfer(1, 8'h00, 8'h4B, 1, -1, 0);
        hold(6);

        // R9: another driver pulls SDA low on wire slot 1 of 0xF0
        rx_lsb = 0; scl_pp = 0; th = 4; tl = 5; td = 2;
        run_xfer(0, 8'hF0, 8'h00, 0, 1, 0);
        hold(6);

        // R8: transfer limit of 40 busy cycles
        tlim = 40;
        run_xfer(0, 8'h5A, 8'h00, 1, -1, 0);
        hold(6);

        // R2, R6, R7: zero start/stop counts, flags cleared by the next go
        ts = 0; tp = 0; th = 1; tl = 2; td = 1; tlim = 1000;
        run_xfer(0, 8'h81, 8'h00, 1, -1, 0);
        hold(6);

        cmp_en = 0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule